// File: doc/BRIEF.md
# Non-Cacheable Address Region Decoder

This block keeps the small set of configuration registers that say which parts of physical memory must bypass the cache. For each 32-bit physical address it produces a registered flag that marks the address as non-cacheable. Software loads the registers one byte at a time through an indexed byte port. The same port gives combinational read-back of the byte that the index selects.

The configuration has three parts. Two fixed legacy windows can be turned on: the bottom 64 KB of every megabyte, and the range from 0xA0000 to 0xFFFFF. There are also four programmable regions. Each region is described by three bytes that hold base-address bits A31..A12 and a 4-bit logarithmic size code. An address is non-cacheable when any enabled window or any enabled region contains it.

Top module: `nc_region_decoder`

## Requirements
- R1: After reset, every address is reported cacheable, and every index reads back as zero.
- R2: Region k (k = 0..3) uses indices 0xC4+3k, 0xC5+3k and 0xC6+3k. Byte 0 holds base A31..A24, byte 1 holds A23..A16, and byte 2 holds A15..A12 in bits [7:4] with the size code in bits [3:0]. A written byte reads back unchanged at its index.
- R3: Index 0xC0 stores only bits [1:0] and index 0xC1 stores only bit 0. All their other bits read as zero.
- R4: A write to any index other than 0xC0, 0xC1 and 0xC4..0xCF changes nothing, and such an index reads as zero.
- R5: A region whose size code is 0 matches no address.
- R6: Size codes 1..14 give a region of 4 KB << (code-1) bytes. Base bits below that size are ignored, so a misaligned base acts as if it were rounded down to the size.
- R7: Size code 15 matches every address.
- R8: With bit 0 of index 0xC0 set, every address whose bits [19:16] are all zero is non-cacheable.
- R9: With bit 1 of index 0xC0 set, addresses 0xA0000 through 0xFFFFF are non-cacheable.
- R10: The flag is the OR of all matches. It is computed from the address and the configuration as they stand at one rising edge, and it appears on `nc_flag` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_idx | input | 8 | Register index for write and read-back |
| cfg_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Read-back byte at `cfg_idx` |
| addr | input | 32 | Physical address to classify |
| nc_flag | output | 1 | Registered non-cacheable flag |

## Verification
The assertions assume two things about the inputs. Reset is never asserted in the middle of a write. The index held by read-back checks stays stable for the whole cycle in which it is compared. The bench meets both by changing every input on the falling clock edge and by deasserting reset before its first write. Because random configurations would rarely enable the 4 GB code, the stimulus gives it a low weight. The boundary addresses of each region are taken from the rounded-down base, so misaligned bases are covered as well.

// File: rtl/nc_region_decoder.sv
module nc_region_decoder #(
  parameter int          NREG     = 4,
  parameter logic [7:0]  CTL0_IDX = 8'hC0,
  parameter logic [7:0]  CTL1_IDX = 8'hC1,
  parameter logic [7:0]  DESC_IDX = 8'hC4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_idx,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic [31:0] addr,
  output logic        nc_flag
);
  localparam int NBYTES = 3 * NREG;
  localparam int OW     = $clog2(NBYTES);

  logic [7:0] dbyte [NBYTES];
  logic [1:0] ctl0;
  logic       ctl1;

  logic [7:0]    off;
  logic          in_desc;
  logic [OW-1:0] sel;

  assign off     = cfg_idx - DESC_IDX;
  assign in_desc = (cfg_idx >= DESC_IDX) && (off < 8'(NBYTES));
  assign sel     = off[OW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl0 <= '0;
      ctl1 <= 1'b0;
      for (int i = 0; i < NBYTES; i++) dbyte[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_idx == CTL0_IDX)      ctl0 <= cfg_wdata[1:0];
      else if (cfg_idx == CTL1_IDX) ctl1 <= cfg_wdata[0];
      else if (in_desc)             dbyte[sel] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx == CTL0_IDX)      cfg_rdata = {6'b0, ctl0};
    else if (cfg_idx == CTL1_IDX) cfg_rdata = {7'b0, ctl1};
    else if (in_desc)             cfg_rdata = dbyte[sel];
  end

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [3:0]  code;
    logic [19:0] base, mask;
    assign code = dbyte[3*g+2][3:0];
    assign base = {dbyte[3*g], dbyte[3*g+1], dbyte[3*g+2][7:4]};
    assign mask = (code == 4'd15) ? 20'd0 : ~((20'd1 << (code - 4'd1)) - 20'd1);
    assign hit[g] = (code != 4'd0) && (((addr[31:12] ^ base) & mask) == 20'd0);
  end

  logic lo_win, hi_win, nc_next;
  assign lo_win  = ctl0[0] && (addr[19:16] == 4'd0);
  assign hi_win  = ctl0[1] && (addr[31:20] == 12'd0) && (addr[19:0] >= 20'hA0000);
  assign nc_next = (|hit) || lo_win || hi_win;

  always_ff @(posedge clk) begin
    if (!rst_n) nc_flag <= 1'b0;
    else        nc_flag <= nc_next;
  end
endmodule

// File: rtl/nc_region_decoder_chk.sv
module nc_region_decoder_chk #(
  parameter int NREG = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  cfg_idx,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [31:0] addr,
  input logic        nc_flag,
  input logic [1:0]  ctl0
);
  logic is_desc, is_impl;
  assign is_desc = (cfg_idx >= 8'hC4) && (cfg_idx < 8'(8'hC4 + 3 * NREG));
  assign is_impl = is_desc || cfg_idx == 8'hC0 || cfg_idx == 8'hC1;

  p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_impl |-> cfg_rdata == 8'h00);

  p_ctl0_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_idx == 8'hC0 |-> cfg_rdata[7:2] == 6'd0);

  p_ctl1_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_idx == 8'hC1 |-> cfg_rdata[7:1] == 7'd0);

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && is_desc |=> (cfg_idx != $past(cfg_idx)) || (cfg_rdata == $past(cfg_wdata)));

  p_lo_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl0[0] && addr[19:16] == 4'd0 |=> nc_flag);

  p_hi_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl0[1] && addr >= 32'h000A0000 && addr <= 32'h000FFFFF |=> nc_flag);
endmodule

bind nc_region_decoder nc_region_decoder_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr(addr),
  .nc_flag(nc_flag), .ctl0(ctl0)
);

// File: tb/sim_nc_region_decoder.sv
module sim_nc_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_idx = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [31:0] addr = 32'h0;
  logic        nc_flag;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_byte [12];
  logic [1:0] m_ctl0;
  logic       m_ctl1;

  always #5 clk = ~clk;

  nc_region_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr(addr), .nc_flag(nc_flag)
  );

  function automatic logic [7:0] exp_rd(logic [7:0] idx);
    if (idx == 8'hC0) return {6'b0, m_ctl0};
    if (idx == 8'hC1) return {7'b0, m_ctl1};
    if (idx >= 8'hC4 && idx <= 8'hCF) return m_byte[idx - 8'hC4];
    return 8'h00;
  endfunction

  function automatic longint unsigned reg_lo(int k);
    longint unsigned b, sz;
    logic [3:0] c;
    c  = m_byte[3*k+2][3:0];
    b  = {32'h0, m_byte[3*k], m_byte[3*k+1], m_byte[3*k+2][7:4], 12'h000};
    sz = 64'h1000 << (c - 1);
    return b - (b % sz);
  endfunction

  function automatic bit exp_nc(logic [31:0] a);
    longint unsigned av, lo, sz;
    logic [3:0] c;
    av = {32'h0, a};
    for (int k = 0; k < 4; k++) begin
      c = m_byte[3*k+2][3:0];
      if (c == 4'd15) return 1'b1;
      if (c != 4'd0) begin
        sz = 64'h1000 << (c - 1);
        lo = reg_lo(k);
        if (av >= lo && av < lo + sz) return 1'b1;
      end
    end
    if (m_ctl0[0] && (av % 64'h100000) < 64'h10000) return 1'b1;
    if (m_ctl0[1] && av >= 64'hA0000 && av < 64'h100000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 8'hC0) m_ctl0 = d[1:0];
    else if (idx == 8'hC1) m_ctl1 = d[0];
    else if (idx >= 8'hC4 && idx <= 8'hCF) m_byte[idx - 8'hC4] = d;
  endtask

  task automatic set_reg(int k, logic [19:0] base, logic [3:0] code);
    wr(8'(8'hC4 + 3*k), base[19:12]);
    wr(8'(8'hC5 + 3*k), base[11:4]);
    wr(8'(8'hC6 + 3*k), {base[3:0], code});
  endtask

  task automatic chk_rd(logic [7:0] idx, string req);
    cfg_idx = idx;
    #1;
    n_chk++;
    if (cfg_rdata !== exp_rd(idx)) begin
      n_bad++;
      $display("FAIL %s idx=%h got=%h exp=%h", req, idx, cfg_rdata, exp_rd(idx));
    end
  endtask

  task automatic chk_nc(logic [31:0] a, string req);
    addr = a;
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (nc_flag !== exp_nc(a)) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%b exp=%b", req, a, nc_flag, exp_nc(a));
    end
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    m_ctl0 = '0; m_ctl1 = 1'b0;
    for (int i = 0; i < 12; i++) m_byte[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_nc(32'h0000_0000, "R1");
    chk_nc(32'h000A_0000, "R1");
    chk_rd(8'hC0, "R1");
    chk_rd(8'hC6, "R1");

    // R3 control registers
    wr(8'hC0, 8'hFF); chk_rd(8'hC0, "R3");
    wr(8'hC1, 8'hFF); chk_rd(8'hC1, "R3");
    // R8 / R9 fixed windows
    wr(8'hC0, 8'h01);
    chk_nc(32'h0530_FFFF, "R8"); chk_nc(32'h0531_0000, "R8"); chk_nc(32'h000A_0000, "R8");
    wr(8'hC0, 8'h02);
    chk_nc(32'h0009_FFFF, "R9"); chk_nc(32'h000A_0000, "R9");
    chk_nc(32'h000F_FFFF, "R9"); chk_nc(32'h0010_0000, "R9"); chk_nc(32'h001A_0000, "R9");
    wr(8'hC0, 8'h00);

    // R4 unimplemented indices
    wr(8'hC2, 8'h5A); chk_rd(8'hC2, "R4");
    wr(8'hD0, 8'hA5); chk_rd(8'hD0, "R4");
    chk_rd(8'hBF, "R4");
    chk_nc(32'h0000_0000, "R4");

    // R2 read-back of every descriptor byte
    for (int i = 0; i < 12; i++) begin
      wr(8'(8'hC4 + i), 8'(8'h30 + 7*i));
      chk_rd(8'(8'hC4 + i), "R2");
    end
    for (int k = 0; k < 4; k++) set_reg(k, 20'h0, 4'd0);

    // R5 disabled region
    set_reg(0, 20'h12345, 4'd0);
    chk_nc(32'h1234_5000, "R5");
    // R6 misaligned base, 64 KB
    set_reg(0, 20'h00123, 4'd5);
    chk_nc(32'h0012_0000, "R6"); chk_nc(32'h0012_FFFF, "R6");
    chk_nc(32'h0013_0000, "R6"); chk_nc(32'h0011_FFFF, "R6");
    // R6 largest finite code, 32 MB
    set_reg(1, 20'hFE000, 4'd14);
    chk_nc(32'hFE00_0000, "R6"); chk_nc(32'hFFFF_FFFF, "R6"); chk_nc(32'hFDFF_FFFF, "R6");
    // R7 whole space
    set_reg(3, 20'h00000, 4'd15);
    chk_nc(32'h7777_1234, "R7"); chk_nc(32'h0000_0000, "R7");
    for (int k = 0; k < 4; k++) set_reg(k, 20'h0, 4'd0);

    // R10 random configurations with boundary addresses
    for (int it = 0; it < 150; it++) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] c;
        c = 4'($urandom % 15);
        if ($urandom % 10 == 0) c = 4'd15;
        set_reg(k, 20'($urandom), c);
      end
      wr(8'hC0, 8'($urandom % 4));
      for (int k = 0; k < 4; k++) begin
        logic [3:0] c;
        longint unsigned lo, sz;
        c = m_byte[3*k+2][3:0];
        if (c != 4'd0 && c != 4'd15) begin
          sz = 64'h1000 << (c - 1);
          lo = reg_lo(k);
          chk_nc(32'(lo), "R10");
          chk_nc(32'(lo + sz - 1), "R10");
          chk_nc(32'(lo + sz), "R10");
          chk_nc(32'(lo - 1), "R10");
        end
      end
      for (int j = 0; j < 4; j++) chk_nc($urandom, "R10");
      chk_rd(8'(8'hC4 + $urandom % 12), "R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule